// File: doc/BRIEF.md
# Indirect Subport Register Bank

This block is a peripheral that sits on a 4-bit processor I/O bus and answers to a single module address. Up to sixteen internal registers, called subports, sit behind that one address and are reached indirectly. A write (OUT) to the module address while the block waits for a pointer stores a 4-bit subport number. The access to the module address that follows moves data to or from the chosen subport. That access may be a read (IN) or a write.

Each subport is a nibble register or a byte register, fixed per subport by a parameter mask. A nibble subport needs one data access, and the block then waits for a new pointer. A byte subport needs two nibble accesses. A byte write sends the low nibble first and then the high nibble. A byte read returns the high nibble first and then the low nibble. A byte write is committed as a whole on its second nibble. A byte read takes a copy of the low nibble when the high nibble is read. A read issued while the block waits for a pointer returns the stored pointer and leaves the block in that state, so software can find out where it is.

Top module: `subport_bank`

## Requirements
- R1: Synchronous active-low reset clears the pointer, returns the block to the pointer-wait state (`data_phase` = 0) and clears every subport to zero.
- R2: An access whose address differs from `MOD_ADDR` has no effect. The block keeps its state and subport contents, `bus_rdata_en` stays 0 and `bus_rdata` reads 0.
- R3: An OUT to the module address in the pointer-wait state stores `bus_wdata` as the subport number and moves the block to the data state (`data_phase` = 1).
- R4: An IN to the module address in the pointer-wait state returns the stored pointer with `bus_rdata_en` = 1, and the block stays in the pointer-wait state.
- R5: For a subport whose bit in `BYTE_MASK` is 0, one data access completes the transfer. An OUT writes bits 3:0 and an IN returns bits 3:0. Bits 7:4 of that subport always read 0 on `sub_regs`, and the block then returns to the pointer-wait state.
- R6: For a subport whose bit in `BYTE_MASK` is 1, a write is a low-nibble OUT followed by a high-nibble OUT. The subport is unchanged after the first OUT and holds the whole byte after the second.
- R7: For a byte subport, a read is an IN that returns bits 7:4 followed by an IN that returns bits 3:0. The block then returns to the pointer-wait state.
- R8: The second access of a byte transfer uses a held nibble. That nibble is the written low nibble after a first OUT, or bits 3:0 of the subport after a first IN. A second OUT writes {bus_wdata, held nibble} and a second IN returns the held nibble.
- R9: When `bus_wr` and `bus_rd` are both high, the access is treated as an OUT and `bus_rdata_en` stays 0.
- R10: `bus_rdata` is 0 whenever `bus_rdata_en` is 0.
- R11: Subport i occupies `sub_regs[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | I/O bus module address |
| bus_wr | input | 1 | OUT strobe, one cycle per access |
| bus_rd | input | 1 | IN strobe, one cycle per access |
| bus_wdata | input | 4 | Nibble written by an OUT |
| bus_rdata | output | 4 | Nibble returned by an IN, valid in the strobe cycle |
| bus_rdata_en | output | 1 | High when this block drives read data |
| data_phase | output | 1 | 1 when the next module access is a data transfer |
| sub_regs | output | 8*NUM_PORTS | Contents of all subports, zero-extended to bytes |

## Verification
The hardest case to reach is the second nibble of a byte transfer whose direction differs from the first nibble. In that case the held nibble, not the subport, sets the outcome. The bench reaches it by following a pointer load to a byte subport with an IN and then an OUT, and again with an OUT and then an IN. It checks the resulting byte on `sub_regs` and the returned nibble. The foreign-address sweep runs in both the pointer-wait and the data state, so a stray decode cannot move the phase in either state. A reset is also applied in the middle of a transfer.

// File: rtl/subport_pkg.sv
// Shared types for the indirect subport bank.
// Assumes a 4-bit data bus and at most sixteen subports.
package subport_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;
    localparam int MAX_PORTS = 16;

    // Sequencing state of the indirect access protocol
    typedef enum logic [1:0] {
        PH_PTR    = 2'd0,   // next module access loads the pointer
        PH_FIRST  = 2'd1,   // next access moves the first data nibble
        PH_SECOND = 2'd2    // next access moves the second nibble of a byte
    } phase_e;

    // One qualified bus access aimed at this module
    typedef struct packed {
        logic wr;
        logic rd;
    } access_t;

endpackage

// File: rtl/subport_decode.sv
// Module address decoder.
// Qualifies the bus strobes against the module address. A write strobe
// wins over a read strobe given in the same cycle.
// Assumes the strobes last one cycle per bus access.
module subport_decode #(
    parameter int          ADDR_W   = 4,
    parameter logic [3:0]  MOD_ADDR = 4'hA
) (
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    output subport_pkg::access_t  acc
);

    logic sel;

    // Address match for this module
    always_comb sel = (bus_addr == ADDR_W'(MOD_ADDR));

    // Qualified strobes, write has priority
    always_comb begin
        acc.wr = sel & bus_wr;
        acc.rd = sel & bus_rd & ~bus_wr;
    end

endmodule

// File: rtl/subport_seq.sv
// Access sequencer for the indirect bank.
// Holds the pointer, the phase and the held nibble used by byte
// transfers. Produces the write request for the register bank and the
// read nibble. Assumes rd_val is the current content of subport ptr_q.
module subport_seq #(
    parameter int               NUM_PORTS = 16,
    parameter logic [15:0]      BYTE_MASK = 16'hCA53
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  subport_pkg::access_t  acc,
    input  logic [3:0]            wdata,
    input  logic [7:0]            rd_val,
    output logic [3:0]            ptr_q,
    output logic                  data_phase,
    output logic [3:0]            rdata,
    output logic                  wr_en,
    output logic [7:0]            wr_val
);
    import subport_pkg::*;

    phase_e     ph_q, ph_d;
    logic [3:0] ptr_d;
    logic [3:0] hold_q, hold_d;
    logic       ptr_in_range;
    logic       ptr_is_byte;

    // Width attribute of the selected subport
    always_comb begin
        ptr_in_range = (int'(ptr_q) < NUM_PORTS);
        ptr_is_byte  = ptr_in_range & BYTE_MASK[ptr_q];
    end

    // Next-state, write request and read data
    always_comb begin
        ph_d   = ph_q;
        ptr_d  = ptr_q;
        hold_d = hold_q;
        wr_en  = 1'b0;
        wr_val = '0;
        rdata  = '0;
        unique case (ph_q)
            PH_PTR: begin
                if (acc.wr) begin
                    ptr_d = wdata;
                    ph_d  = PH_FIRST;
                end else if (acc.rd) begin
                    rdata = ptr_q;
                end
            end
            PH_FIRST: begin
                if (acc.wr) begin
                    if (ptr_is_byte) begin
                        hold_d = wdata;
                        ph_d   = PH_SECOND;
                    end else begin
                        wr_en  = 1'b1;
                        wr_val = {4'h0, wdata};
                        ph_d   = PH_PTR;
                    end
                end else if (acc.rd) begin
                    if (ptr_is_byte) begin
                        rdata  = rd_val[7:4];
                        hold_d = rd_val[3:0];
                        ph_d   = PH_SECOND;
                    end else begin
                        rdata = rd_val[3:0];
                        ph_d  = PH_PTR;
                    end
                end
            end
            PH_SECOND: begin
                if (acc.wr) begin
                    wr_en  = 1'b1;
                    wr_val = {wdata, hold_q};
                    ph_d   = PH_PTR;
                end else if (acc.rd) begin
                    rdata = hold_q;
                    ph_d  = PH_PTR;
                end
            end
            default: ph_d = PH_PTR;
        endcase
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_PTR;
            ptr_q  <= '0;
            hold_q <= '0;
        end else begin
            ph_q   <= ph_d;
            ptr_q  <= ptr_d;
            hold_q <= hold_d;
        end
    end

    // Phase indication for the top level
    always_comb data_phase = (ph_q != PH_PTR);

endmodule

// File: rtl/subport_regfile.sv
// Bank of subport registers.
// Each slot is four or eight bits wide according to BYTE_MASK. Nibble
// slots are zero-extended on the flat output. Writes to an index
// beyond NUM_PORTS are dropped.
module subport_regfile #(
    parameter int           NUM_PORTS = 16,
    parameter logic [15:0]  BYTE_MASK = 16'hCA53,
    localparam int          FLAT_W    = NUM_PORTS * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        idx,
    input  logic [7:0]        wr_val,
    output logic [7:0]        rd_val,
    output logic [FLAT_W-1:0] regs_flat
);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slot
        if (BYTE_MASK[i]) begin : g_byte
            logic [7:0] q;
            // Byte slot storage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && idx == 4'(i))
                    q <= wr_val;
            end
            assign regs_flat[i*8 +: 8] = q;
        end else begin : g_nib
            logic [3:0] q;
            // Nibble slot storage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && idx == 4'(i))
                    q <= wr_val[3:0];
            end
            assign regs_flat[i*8 +: 8] = {4'h0, q};
        end
    end

    // Read mux for the selected slot
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            if (idx == 4'(k))
                rd_val = regs_flat[k*8 +: 8];
        end
    end

endmodule

// File: rtl/subport_bank.sv
// Indirect subport register bank, top level.
// Connects the address decoder, the sequencer and the register bank.
// Assumes a 4-bit I/O bus with one-cycle strobes. Read data is
// combinational in the strobe cycle.
module subport_bank #(
    parameter logic [3:0]  MOD_ADDR  = 4'hA,
    parameter int          NUM_PORTS = 16,
    parameter logic [15:0] BYTE_MASK = 16'hCA53,
    localparam int         FLAT_W    = NUM_PORTS * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_wdata,
    output logic [3:0]        bus_rdata,
    output logic              bus_rdata_en,
    output logic              data_phase,
    output logic [FLAT_W-1:0] sub_regs
);
    import subport_pkg::*;

    access_t    acc;
    logic [3:0] ptr;
    logic [7:0] rd_val;
    logic [7:0] wr_val;
    logic       wr_en;
    logic [3:0] seq_rdata;

    subport_decode #(
        .ADDR_W   (4),
        .MOD_ADDR (MOD_ADDR)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .acc      (acc)
    );

    subport_seq #(
        .NUM_PORTS (NUM_PORTS),
        .BYTE_MASK (BYTE_MASK)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .wdata      (bus_wdata),
        .rd_val     (rd_val),
        .ptr_q      (ptr),
        .data_phase (data_phase),
        .rdata      (seq_rdata),
        .wr_en      (wr_en),
        .wr_val     (wr_val)
    );

    subport_regfile #(
        .NUM_PORTS (NUM_PORTS),
        .BYTE_MASK (BYTE_MASK)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .idx       (ptr),
        .wr_val    (wr_val),
        .rd_val    (rd_val),
        .regs_flat (sub_regs)
    );

    // Bus read drive
    always_comb begin
        bus_rdata_en = acc.rd;
        bus_rdata    = acc.rd ? seq_rdata : 4'h0;
    end

endmodule

// File: rtl/subport_bank_chk.sv
// Protocol checker for subport_bank, bound to every instance.
// Observes only the top-level ports.
module subport_bank_chk #(
    parameter logic [3:0]  MOD_ADDR  = 4'hA,
    parameter int          NUM_PORTS = 16,
    localparam int         FLAT_W    = NUM_PORTS * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [3:0]        bus_rdata,
    input logic              bus_rdata_en,
    input logic              data_phase,
    input logic [FLAT_W-1:0] sub_regs
);

    logic hit;
    always_comb hit = (bus_addr == MOD_ADDR) && (bus_wr || bus_rd);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (sub_regs == '0 && !data_phase));

    assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(sub_regs) && $stable(data_phase)));

    assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && !data_phase) |=> data_phase);

    assert_ptr_read_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_rd && !bus_wr && !data_phase) |=> (!data_phase && $stable(sub_regs)));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !bus_rdata_en);

    assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_en |-> (bus_rdata == 4'h0));

endmodule

bind subport_bank subport_bank_chk #(
    .MOD_ADDR  (MOD_ADDR),
    .NUM_PORTS (NUM_PORTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .bus_rdata_en (bus_rdata_en),
    .data_phase   (data_phase),
    .sub_regs     (sub_regs)
);

// File: tb/tb_subport_bank.sv
// Self-checking bench: sweeps every subport of the default bank.
module tb_subport_bank;

    localparam logic [3:0]  MOD  = 4'hA;
    localparam int          NP   = 16;
    localparam logic [15:0] MASK = 16'hCA53;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     bus_addr = 4'h0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [3:0]     bus_wdata = 4'h0;
    logic [3:0]     bus_rdata;
    logic           bus_rdata_en;
    logic           data_phase;
    logic [NP*8-1:0] sub_regs;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [NP];
    logic [3:0] cap_rdata;
    logic       cap_en;

    always #4 clk = ~clk;   // 125 MHz

    subport_bank #(.MOD_ADDR(MOD), .NUM_PORTS(NP), .BYTE_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdata_en(bus_rdata_en), .data_phase(data_phase), .sub_regs(sub_regs)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, sample read data mid-cycle
    task automatic bus(input logic [3:0] a, input logic w, input logic r, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #2;
        cap_rdata = bus_rdata;
        cap_en    = bus_rdata_en;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic check_model(input string req);
        logic [NP*8-1:0] flat;
        for (int k = 0; k < NP; k++) flat[k*8 +: 8] = model[k];
        check(req, 128'(sub_regs), 128'(flat));
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NP; k++) model[k] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_model("R1 regs");
        check("R1 phase", 128'(data_phase), 128'(0));
        bus(MOD, 0, 1, 4'h0);
        check("R4 ptr after reset", 128'({cap_en, cap_rdata}), 128'({1'b1, 4'h0}));

        // Write sweep over every subport
        for (int i = 0; i < NP; i++) begin
            logic [7:0] v;
            v = 8'((i * 29 + 7) & 255);
            bus(MOD, 1, 0, 4'(i));
            check("R3 enter data", 128'(data_phase), 128'(1));
            if (MASK[i]) begin
                bus(MOD, 1, 0, v[3:0]);
                check("R6 unchanged after low", 128'(sub_regs[i*8 +: 8]), 128'(model[i]));
                bus(MOD, 1, 0, v[7:4]);
                model[i] = v;
                check("R6 byte written", 128'(sub_regs[i*8 +: 8]), 128'(v));
            end else begin
                bus(MOD, 1, 0, v[3:0]);
                model[i] = {4'h0, v[3:0]};
                check("R5 nibble written", 128'(sub_regs[i*8 +: 8]), 128'(model[i]));
            end
            check("R5 R6 back to pointer", 128'(data_phase), 128'(0));
            bus(MOD, 0, 1, 4'h0);
            check("R4 ptr readback", 128'({cap_en, cap_rdata, data_phase}), 128'({1'b1, 4'(i), 1'b0}));
        end
        check_model("R11 layout");

        // Read sweep
        for (int i = 0; i < NP; i++) begin
            bus(MOD, 1, 0, 4'(i));
            if (MASK[i]) begin
                bus(MOD, 0, 1, 4'h0);
                check("R7 high first", 128'({cap_en, cap_rdata}), 128'({1'b1, model[i][7:4]}));
                bus(MOD, 0, 1, 4'h0);
                check("R7 low second", 128'({cap_en, cap_rdata}), 128'({1'b1, model[i][3:0]}));
            end else begin
                bus(MOD, 0, 1, 4'h0);
                check("R5 nibble read", 128'({cap_en, cap_rdata}), 128'({1'b1, model[i][3:0]}));
            end
            check("R7 back to pointer", 128'(data_phase), 128'(0));
        end

        // R2 foreign addresses in pointer state and in data state
        for (int ph = 0; ph < 2; ph++) begin
            if (ph == 1) bus(MOD, 1, 0, 4'h2);
            for (int a = 0; a < 16; a++) begin
                if (4'(a) != MOD) begin
                    bus(4'(a), 1, 0, 4'h3);
                    bus(4'(a), 0, 1, 4'h0);
                    check("R2 R10 no drive", 128'({cap_en, cap_rdata}), 128'(0));
                end
            end
            check("R2 phase kept", 128'(data_phase), 128'(ph));
            check_model("R2 regs kept");
        end
        bus(MOD, 1, 0, 4'h9);
        model[2] = 8'h09;
        check_model("R5 after foreign sweep");

        // R8 read then write on a byte subport
        bus(MOD, 1, 0, 4'h0);
        bus(MOD, 0, 1, 4'h0);
        check("R8 first read", 128'(cap_rdata), 128'(model[0][7:4]));
        bus(MOD, 1, 0, 4'h5);
        model[0] = {4'h5, model[0][3:0]};
        check_model("R8 mixed write");
        // R8 write then read on a byte subport
        bus(MOD, 1, 0, 4'h0);
        bus(MOD, 1, 0, 4'hC);
        bus(MOD, 0, 1, 4'h0);
        check("R8 held nibble", 128'({cap_en, cap_rdata}), 128'({1'b1, 4'hC}));
        check_model("R8 subport unchanged");

        // R9 simultaneous strobes act as OUT
        bus(MOD, 1, 1, 4'h6);
        check("R9 no read drive", 128'({cap_en, cap_rdata}), 128'(0));
        check("R9 pointer loaded", 128'(data_phase), 128'(1));
        bus(MOD, 0, 1, 4'h0);
        check("R9 selected subport", 128'(cap_rdata), 128'(model[6][7:4]));
        bus(MOD, 0, 1, 4'h0);

        // R1 reset during a transfer
        bus(MOD, 1, 0, 4'h3);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int k = 0; k < NP; k++) model[k] = 8'h00;
        check_model("R1 mid reset regs");
        check("R1 mid reset phase", 128'(data_phase), 128'(0));
        bus(MOD, 0, 1, 4'h0);
        check("R1 pointer cleared", 128'({cap_en, cap_rdata}), 128'({1'b1, 4'h0}));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule